// File: doc/BRIEF.md
# Control Cell Transmit Mailbox

This block holds a single outgoing control cell for a local processor and places it onto a shared byte-serial cell bus. The processor loads the cell one byte at a time into a private buffer. It then arms the mailbox by writing a go bit. The mailbox waits until the data-cell path reports that nothing is queued ahead of it. It then streams the cell out in ascending byte order, one byte per accepted bus handshake.

When the last byte has been taken, the mailbox drops its ready flag and raises a sticky sent flag. The processor uses the sent flag to know that the buffer may be refilled. The destination later reports delivery as a one-cycle acknowledge or refusal pulse. The mailbox latches each pulse into its own sticky flag. Each of the three flags can be routed to a shared interrupt line through its own enable. Nothing in the block depends on the chip's online setting, so control traffic keeps working while the data path is offline.

Top module: `ctl_cell_tx_mailbox`

## Requirements
- R1: After reset, cell_ready, cell_sent, dst_ack, dst_nak, bus_valid and irq are all 0.
- R2: A write on the register port at address 0 with bit 0 set arms the mailbox, and cell_ready reads 1 on the following cycle.
- R3: While cell_ready is 1 and data_pending is 1 before streaming has begun, bus_valid stays 0.
- R4: Once streaming starts, bytes leave in index order 0 up to CELL_BYTES-1, one per cycle with bus_valid and bus_ready both high. The byte equals what was last written at that index, and bus_last is 1 exactly on the final byte.
- R5: While bus_valid is 1 and bus_ready is 0, bus_valid stays 1 and bus_data is held.
- R6: On the cycle after the final handshake, cell_ready is 0, cell_sent is 1 and bus_valid is 0.
- R7: Buffer writes made while cell_ready is 1 are discarded, so the streamed cell keeps its earlier contents.
- R8: A go write while cell_ready is 1 is ignored: streaming neither restarts nor skips bytes.
- R9: A one-cycle pulse on rmt_ack or rmt_nak sets dst_ack or dst_nak. The flag stays set until the register port writes address 1 with the matching bit set: bit 0 for sent, bit 1 for ack, bit 2 for nak. A set and a clear in the same cycle leave the flag set.
- R10: irq is 1 exactly when some flag is set together with its enable. Enables are written at register address 2: bit 0 for sent, bit 1 for ack, bit 2 for nak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_idx | input | IDX_W (6) | Byte index for the buffer write |
| buf_wdata | input | DATA_W (8) | Byte to store |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 flag clear, 2 interrupt enables |
| reg_wdata | input | 8 | Register write data |
| cell_ready | output | 1 | Cell armed and not yet fully sent |
| cell_sent | output | 1 | Sticky: cell fully handed to the bus |
| dst_ack | output | 1 | Sticky: destination accepted the cell |
| dst_nak | output | 1 | Sticky: destination refused the cell |
| irq | output | 1 | Masked OR of the three flags |
| data_pending | input | 1 | Data cells are still queued ahead of control traffic |
| bus_valid | output | 1 | Byte on bus_data is offered |
| bus_ready | input | 1 | Bus takes the offered byte this cycle |
| bus_data | output | DATA_W (8) | Cell byte |
| bus_last | output | 1 | Offered byte is the final one of the cell |
| rmt_ack | input | 1 | One-cycle delivery acknowledge from the destination |
| rmt_nak | input | 1 | One-cycle delivery refusal from the destination |

## Verification
The bench builds the block with CELL_BYTES at 56 and DATA_W at 8, so every transfer is a full-length cell. Because 56 is not a power of two, the end-of-cell compare must fire at index 55 rather than at an index wrap. Four table rows combine different byte patterns, bus stall patterns and data-pending delays, so the hold behaviour and the start gate are both exercised over the whole cell. Directed runs then inject buffer writes and repeated go writes into an armed mailbox, and work through the set, clear and enable combinations of the three flags.

// File: rtl/ctl_mbox_pkg.sv
// Shared constants and types for the control cell transmit mailbox.
// Assumes an 8-bit register data path and a 2-bit register address.
package ctl_mbox_pkg;

    localparam int REG_W = 8;

    // Register addresses on the processor port
    localparam logic [1:0] REG_CTL  = 2'd0;
    localparam logic [1:0] REG_CLR  = 2'd1;
    localparam logic [1:0] REG_IEN  = 2'd2;

    // Bit positions shared by the clear and enable registers
    localparam int FLG_SENT = 0;
    localparam int FLG_ACK  = 1;
    localparam int FLG_NAK  = 2;

    // Bit position of the go bit in the control register
    localparam int CTL_GO = 0;

    typedef enum logic [1:0] {
        SND_IDLE = 2'd0,
        SND_WAIT = 2'd1,
        SND_XFER = 2'd2
    } snd_state_t;

endpackage

// File: rtl/ctl_cell_buf.sv
// Single-cell byte buffer.
// Stores CELL_BYTES bytes written by the processor and drops any write
// while lock is high or when the index lies past the last byte.
// Read is combinational, so the byte at rd_idx is valid in the same cycle.
// Assumes rd_idx never exceeds CELL_BYTES-1.
module ctl_cell_buf #(
    parameter int CELL_BYTES = 56,
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

    logic [DATA_W-1:0] mem [CELL_BYTES];
    logic              wr_ok;

    // Accept a write only when unlocked and the index is in range
    assign wr_ok = wr_en && !lock && (wr_idx <= LAST_IDX);

    // Store one byte per accepted write
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Present the byte selected by the sender
    assign rd_data = mem[rd_idx];

    // R7: a locked write leaves the addressed byte unchanged
    a_r7_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_en && (wr_idx <= LAST_IDX))
        |=> (mem[$past(wr_idx)] == $past(mem[wr_idx])));

endmodule

// File: rtl/ctl_cell_sender.sv
// Transmit sequencer for the control cell.
// IDLE waits for a go request. WAIT holds until no data cells are pending.
// XFER walks the byte index upward, advancing on each accepted handshake.
// A go request outside IDLE is ignored. done pulses on the final handshake,
// in the same cycle as the return to IDLE.
module ctl_cell_sender
    import ctl_mbox_pkg::*;
#(
    parameter int CELL_BYTES = 56,
    parameter int IDX_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             data_pending,
    input  logic             bus_ready,
    output logic [IDX_W-1:0] rd_idx,
    output logic             bus_valid,
    output logic             bus_last,
    output logic             armed,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

    snd_state_t       state;
    logic [IDX_W-1:0] idx;
    logic             at_last;

    assign at_last = (idx == LAST_IDX);

    // Sequence the mailbox through arm, wait and stream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SND_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                SND_IDLE: begin
                    if (go) begin
                        state <= SND_WAIT;
                        idx   <= '0;
                    end
                end
                SND_WAIT: begin
                    if (!data_pending) begin
                        state <= SND_XFER;
                    end
                end
                SND_XFER: begin
                    if (bus_ready) begin
                        if (at_last) begin
                            state <= SND_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= SND_IDLE;
            endcase
        end
    end

    // Decode outputs from the current state
    always_comb begin
        armed     = (state != SND_IDLE);
        bus_valid = (state == SND_XFER);
        bus_last  = bus_valid && at_last;
        done      = bus_valid && bus_ready && at_last;
        rd_idx    = idx;
    end

    // R3: with data pending and no stream started, nothing is offered next cycle
    a_r3_wait_for_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && data_pending) |=> !bus_valid);

    // R5: an unaccepted byte stays offered at the same index
    a_r5_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(rd_idx)));

    // R8: a go request while armed never rewinds an active stream
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_last && go) |=> (rd_idx == $past(rd_idx) + 1'b1));

endmodule

// File: rtl/ctl_cell_status.sv
// Sticky flags and interrupt mask for the mailbox.
// The sent, ack and nak flags are set by events and cleared by writing 1
// to the matching bit at the clear address. A set wins over a clear in
// the same cycle. irq is the OR of each flag ANDed with its enable bit.
module ctl_cell_status
    import ctl_mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             set_sent,
    input  logic             set_ack,
    input  logic             set_nak,
    output logic [2:0]       flags,
    output logic             irq
);
    logic [2:0] ien;
    logic [2:0] set_vec;
    logic [2:0] clr_vec;

    // Gather the set events and the clear requests into flag-ordered vectors
    always_comb begin
        set_vec           = '0;
        set_vec[FLG_SENT] = set_sent;
        set_vec[FLG_ACK]  = set_ack;
        set_vec[FLG_NAK]  = set_nak;
        clr_vec = (reg_we && reg_addr == REG_CLR) ? reg_wdata[2:0] : 3'b000;
    end

    // Update the sticky flags, giving a set priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= set_vec | (flags & ~clr_vec);
        end
    end

    // Hold the interrupt enables written by the processor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= '0;
        end else if (reg_we && reg_addr == REG_IEN) begin
            ien <= reg_wdata[2:0];
        end
    end

    // Combine the enabled flags into one interrupt line
    assign irq = |(flags & ien);

    // R9: a destination acknowledge is always recorded
    a_r9_ack_latched: assert property (@(posedge clk) disable iff (!rst_n)
        set_ack |=> flags[FLG_ACK]);

    // R9: a destination refusal is always recorded
    a_r9_nak_latched: assert property (@(posedge clk) disable iff (!rst_n)
        set_nak |=> flags[FLG_NAK]);

    // R9: a flag without a clear request stays set
    a_r9_sticky_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_NAK] && !clr_vec[FLG_NAK]) |=> flags[FLG_NAK]);

endmodule

// File: rtl/ctl_cell_tx_mailbox.sv
// Control cell transmit mailbox, top level.
// The processor fills a one-cell buffer, then writes the go bit.
// After any pending data cells, the cell streams out byte by byte.
// Completion sets a sticky sent flag and clears ready without processor
// action. Remote delivery outcomes are latched as maskable sticky flags.
// Assumes rmt_ack and rmt_nak are single-cycle pulses.
module ctl_cell_tx_mailbox
    import ctl_mbox_pkg::*;
#(
    parameter  int CELL_BYTES = 56,
    parameter  int DATA_W     = 8,
    localparam int IDX_W      = $clog2(CELL_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [IDX_W-1:0]  buf_idx,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              cell_ready,
    output logic              cell_sent,
    output logic              dst_ack,
    output logic              dst_nak,
    output logic              irq,
    input  logic              data_pending,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_last,
    input  logic              rmt_ack,
    input  logic              rmt_nak
);
    logic             go;
    logic             done;
    logic [IDX_W-1:0] rd_idx;
    logic [2:0]       flags;

    // Decode a go request from the control register write
    assign go = reg_we && (reg_addr == REG_CTL) && reg_wdata[CTL_GO];

    ctl_cell_buf #(
        .CELL_BYTES (CELL_BYTES),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_idx  (buf_idx),
        .wr_data (buf_wdata),
        .lock    (cell_ready),
        .rd_idx  (rd_idx),
        .rd_data (bus_data)
    );

    ctl_cell_sender #(
        .CELL_BYTES (CELL_BYTES),
        .IDX_W      (IDX_W)
    ) u_snd (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .data_pending (data_pending),
        .bus_ready    (bus_ready),
        .rd_idx       (rd_idx),
        .bus_valid    (bus_valid),
        .bus_last     (bus_last),
        .armed        (cell_ready),
        .done         (done)
    );

    ctl_cell_status u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .set_sent  (done),
        .set_ack   (rmt_ack),
        .set_nak   (rmt_nak),
        .flags     (flags),
        .irq       (irq)
    );

    // Expose the individual sticky flags
    assign cell_sent = flags[FLG_SENT];
    assign dst_ack   = flags[FLG_ACK];
    assign dst_nak   = flags[FLG_NAK];

    // R6: the final handshake drops ready and raises sent together
    a_r6_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_last) |=> (!cell_ready && cell_sent && !bus_valid));

    // R2: a go write on an idle mailbox arms it
    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> cell_ready);

endmodule

// File: tb/ctl_cell_tx_mailbox_test.sv
// Self-checking bench for the control cell transmit mailbox.
// A vector table drives full cell transfers, then directed tests follow.
module ctl_cell_tx_mailbox_test;
    localparam int CELL = 56;
    localparam int DW   = 8;
    localparam int IW   = $clog2(CELL);

    // Table columns: seed, step, ready stall mask, data-pending cycles
    localparam int NVEC = 4;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h00, 8'h01, 8'hFF, 8'd0},
        {8'hA5, 8'h03, 8'hB2, 8'd5},
        {8'h3C, 8'h11, 8'h55, 8'd2},
        {8'hFF, 8'hFE, 8'h81, 8'd9}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          buf_we = 1'b0;
    logic [IW-1:0] buf_idx = '0;
    logic [DW-1:0] buf_wdata = '0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          data_pending = 1'b0;
    logic          bus_ready = 1'b0;
    logic          rmt_ack = 1'b0;
    logic          rmt_nak = 1'b0;
    logic          cell_ready, cell_sent, dst_ack, dst_nak, irq;
    logic          bus_valid, bus_last;
    logic [DW-1:0] bus_data;

    int n_chk  = 0;
    int n_fail = 0;

    ctl_cell_tx_mailbox #(.CELL_BYTES(CELL), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_wdata(buf_wdata), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cell_ready(cell_ready), .cell_sent(cell_sent),
        .dst_ack(dst_ack), .dst_nak(dst_nak), .irq(irq),
        .data_pending(data_pending), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_data(bus_data), .bus_last(bus_last), .rmt_ack(rmt_ack), .rmt_nak(rmt_nak)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic load(input logic [7:0] seed, input logic [7:0] step);
        for (int i = 0; i < CELL; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_idx = IW'(i); buf_wdata = seed + step * 8'(i);
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    // Accept the whole cell and compare order, data and last marker
    task automatic recv(input logic [7:0] seed, input logic [7:0] step,
                        input logic [7:0] mask, input int go_at);
        int  k = 0;
        int  c = 0;
        bit  go_done = 0;
        int  bad = 0;
        logic [7:0] exp_b;
        while (k < CELL && c < 4000) begin
            @(negedge clk);
            reg_we = 1'b0;
            bus_ready = mask[c % 8];
            c++;
            if (go_at >= 0 && k == go_at && !go_done) begin
                // R8: a repeated go during streaming
                reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01;
                go_done = 1;
            end
            if (bus_valid && bus_ready) begin
                exp_b = seed + step * 8'(k);
                if (bus_data !== exp_b || bus_last !== (k == CELL - 1)) begin
                    bad++;
                    if (bad == 1)
                        chk(1'b0, "R4 byte order/data", int'(bus_data), int'(exp_b));
                end
                k++;
            end
        end
        chk(bad == 0 && k == CELL, "R4 full cell streamed", k, CELL);
        @(negedge clk);
        reg_we = 1'b0; bus_ready = 1'b0;
        chk(!cell_ready && cell_sent && !bus_valid, "R6 ready clear, sent set",
            {cell_ready, cell_sent, bus_valid}, 3'b010);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({cell_ready, cell_sent, dst_ack, dst_nak, bus_valid, irq} == 6'b0,
            "R1 reset outputs", {cell_ready, cell_sent, dst_ack, dst_nak, bus_valid, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of full transfers
        for (int v = 0; v < NVEC; v++) begin
            int pend;
            pend = int'(VEC[v][7:0]);
            load(VEC[v][31:24], VEC[v][23:16]);
            data_pending = (pend != 0);
            reg_write(2'd0, 8'h01);
            chk(cell_ready, "R2 go arms mailbox", cell_ready, 1);
            for (int p = 0; p < pend; p++) begin
                @(negedge clk);
                chk(!bus_valid, "R3 held while data pending", bus_valid, 0);
            end
            data_pending = 1'b0;
            recv(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], -1);
            reg_write(2'd1, 8'h01);
            chk(!cell_sent, "R9 sent cleared by write-1", cell_sent, 0);
        end

        // R7: buffer writes while armed are discarded
        load(8'h5A, 8'h07);
        data_pending = 1'b1;
        reg_write(2'd0, 8'h01);
        @(negedge clk);
        buf_we = 1'b1; buf_idx = '0; buf_wdata = 8'hEE;
        @(negedge clk);
        buf_idx = IW'(CELL - 1);
        @(negedge clk);
        buf_we = 1'b0;
        data_pending = 1'b0;
        recv(8'h5A, 8'h07, 8'hDB, -1); // R7 original bytes still streamed
        reg_write(2'd1, 8'h01);

        // R8: a second go mid-stream neither restarts nor skips
        load(8'h10, 8'h05);
        reg_write(2'd0, 8'h01);
        recv(8'h10, 8'h05, 8'hF7, 20);
        @(negedge clk);
        chk(!cell_ready, "R8 no re-arm after completion", cell_ready, 0);

        // R10: sent flag with its enable
        reg_write(2'd2, 8'h01);
        chk(irq, "R10 irq from sent", irq, 1);
        reg_write(2'd1, 8'h01);
        chk(!irq && !cell_sent, "R10 irq drops after clear", irq, 0);
        reg_write(2'd2, 8'h00);

        // R9: acknowledge latches, masked
        @(negedge clk); rmt_ack = 1'b1;
        @(negedge clk); rmt_ack = 1'b0;
        chk(dst_ack && !dst_nak, "R9 ack latched", {dst_ack, dst_nak}, 2'b10);
        repeat (3) @(negedge clk);
        chk(dst_ack, "R9 ack sticky", dst_ack, 1);
        chk(!irq, "R10 ack masked", irq, 0);
        reg_write(2'd2, 8'h02);
        chk(irq, "R10 ack enabled", irq, 1);

        // R9: refusal latches alongside
        @(negedge clk); rmt_nak = 1'b1;
        @(negedge clk); rmt_nak = 1'b0;
        chk(dst_nak && dst_ack, "R9 nak latched", {dst_ack, dst_nak}, 2'b11);
        reg_write(2'd1, 8'h02);
        chk(!dst_ack && dst_nak, "R9 clear ack only", {dst_ack, dst_nak}, 2'b01);
        chk(!irq, "R10 nak masked", irq, 0);
        reg_write(2'd2, 8'h04);
        chk(irq, "R10 nak enabled", irq, 1);

        // R9: set and clear in the same cycle keep the flag
        reg_write(2'd1, 8'h04);
        chk(!dst_nak, "R9 nak cleared", dst_nak, 0);
        @(negedge clk);
        rmt_nak = 1'b1; reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h04;
        @(negedge clk);
        rmt_nak = 1'b0; reg_we = 1'b0;
        chk(dst_nak, "R9 set wins over clear", dst_nak, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule